// File: doc/BRIEF.md
# Posted and Nonposted Write Queue

This block sits between a system-side write port and an external access engine. It holds complete write transactions, each made of address, data, byte enables and chip-select index, until the engine takes them. Each write is classed as posted or nonposted. A posted write is acknowledged in the cycle it enters the queue. A nonposted write is acknowledged only when the engine reports that its external access has finished.

The queue holds up to `DEPTH` posted writes, eight by default. A nonposted write enters behind any posted writes already queued. After that, no further write is taken until the nonposted access completes, so nonposted traffic is effectively one deep. A per-request flag marks writes aimed at NAND command or address locations. A static control input can promote such writes to posted, whatever their own marking says. The engine performs one access at a time and signals completion with a one-cycle pulse. An idle flag tells software when nothing is queued and nothing is in flight.

Top module: `wr_post_buf`

## Requirements
- R1: A write is accepted in a cycle where `req_valid` and `req_ready` are both 1. When the accepted write is posted (`req_posted` = 1), `rsp_valid` is 1 in that same cycle.
- R2: Up to `DEPTH` posted writes can be held while the engine takes nothing. While `DEPTH` entries are held, `req_ready` is 0. Below that, with no nonposted write outstanding, it is 1.
- R3: Entries reach the engine in exactly the order they were accepted. Address, data, byte enables and chip-select arrive unchanged. While `eng_valid` is 1 and `eng_ready` is 0, the offered entry stays fixed.
- R4: Only one access is in flight at a time. `eng_valid` stays 0 from the cycle after the engine takes an entry until the cycle after the matching `eng_done` pulse.
- R5: A nonposted write (`req_posted` = 0 and not promoted) gives no `rsp_valid` when it is accepted. Its `rsp_valid` comes in the cycle where `eng_done` completes that write's own access.
- R6: From the cycle after a nonposted write is accepted, `req_ready` is 0. It returns to 1 in the cycle after that write's `eng_done`.
- R7: A write with `req_nand` = 1 is treated as posted whenever `force_post` = 1. The effective class is `req_posted | (force_post & req_nand)`.
- R8: `buf_empty` is 1 exactly when no entry is queued and no access is in flight. It falls in the cycle after an accept. It rises in the cycle after the last `eng_done`.
- R9: An `eng_done` pulse while no access is in flight has no effect: no `rsp_valid`, and `buf_empty` stays 1.
- R10: After reset, `buf_empty` = 1, `req_ready` = 1, `eng_valid` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_post | input | 1 | Promote writes flagged `req_nand` to posted |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Queue can accept a write |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | BW | Byte enables |
| req_cs | input | CSW | Chip-select index |
| req_posted | input | 1 | 1 = posted, 0 = nonposted |
| req_nand | input | 1 | 1 = target is a NAND command or address location |
| rsp_valid | output | 1 | Write response pulse |
| eng_valid | output | 1 | Entry offered to the access engine |
| eng_ready | input | 1 | Engine takes the offered entry |
| eng_addr | output | AW | Offered address |
| eng_data | output | DW | Offered data |
| eng_be | output | BW | Offered byte enables |
| eng_cs | output | CSW | Offered chip-select index |
| eng_done | input | 1 | One-cycle pulse: in-flight access finished |
| buf_empty | output | 1 | Nothing queued and nothing in flight |

## Verification
A posted response is combinational with the accept, so the bench samples `rsp_valid` in the accept cycle itself, one time unit after the falling edge. Entry count, in-flight state and the nonposted lock are registered. The bench therefore expects `buf_empty`, `req_ready` and `eng_valid` to change one cycle after the accept or the `eng_done` edge, and it samples them at the next falling edge. A nonposted response is checked in the same sample where the bench's engine model drives `eng_done`. Sweeps cover every fill level from one to `DEPTH` against several engine completion latencies, together with all eight combinations of the posted, NAND and promotion inputs.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic {
        WK_NONPOSTED = 1'b0,
        WK_POSTED    = 1'b1
    } wr_kind_e;

    function automatic wr_kind_e wpb_kind(input logic posted,
                                          input logic nand_loc,
                                          input logic promote);
        return (posted || (promote && nand_loc)) ? WK_POSTED : WK_NONPOSTED;
    endfunction

endpackage

// File: rtl/wpb_classify.sv
module wpb_classify
    import wpb_pkg::*;
(
    input  logic     req_posted,
    input  logic     req_nand,
    input  logic     force_post,
    output wr_kind_e kind
);
    always_comb begin
        kind = wpb_kind(req_posted, req_nand, force_post);
    end
endmodule

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [W-1:0]         push_data,
    input  logic                 pop,
    output logic [W-1:0]         head_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                 full,
    output logic                 empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr] <= push_data;
        end
    end

    assign head_data = mem_q[st_q.rd];
    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
endmodule

// File: rtl/wpb_issue.sv
module wpb_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_np,
    input  logic eng_ready,
    input  logic eng_done,
    output logic eng_valid,
    output logic pop,
    output logic np_done,
    output logic busy
);
    typedef struct packed {
        logic busy;
        logic np_flight;
    } iss_st_t;

    iss_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        eng_valid = head_valid && !st_q.busy;
        pop       = eng_valid && eng_ready;
        np_done   = eng_done && st_q.busy && st_q.np_flight;
        if (pop) begin
            st_d.busy      = 1'b1;
            st_d.np_flight = head_np;
        end else if (eng_done && st_q.busy) begin
            st_d.busy      = 1'b0;
            st_d.np_flight = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/wr_post_buf.sv
module wr_post_buf
    import wpb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int CSW   = 3,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           force_post,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    input  logic [BW-1:0]  req_be,
    input  logic [CSW-1:0] req_cs,
    input  logic           req_posted,
    input  logic           req_nand,
    output logic           rsp_valid,
    output logic           eng_valid,
    input  logic           eng_ready,
    output logic [AW-1:0]  eng_addr,
    output logic [DW-1:0]  eng_data,
    output logic [BW-1:0]  eng_be,
    output logic [CSW-1:0] eng_cs,
    input  logic           eng_done,
    output logic           buf_empty
);
    localparam int EW = 1 + CSW + BW + AW + DW;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic np_pending;
    } top_st_t;

    top_st_t st_d, st_q;

    wr_kind_e       kind;
    logic           accept;
    logic           fifo_full, fifo_empty, pop, np_done, busy;
    logic [CW-1:0]  fifo_cnt;
    logic [EW-1:0]  push_word, head_word;

    wpb_classify cls_i (
        .req_posted (req_posted),
        .req_nand   (req_nand),
        .force_post (force_post),
        .kind       (kind)
    );

    assign push_word = {(kind == WK_NONPOSTED), req_cs, req_be, req_addr, req_data};

    wpb_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (push_word),
        .pop       (pop),
        .head_data (head_word),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    wpb_issue iss_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!fifo_empty),
        .head_np    (head_word[EW-1]),
        .eng_ready  (eng_ready),
        .eng_done   (eng_done),
        .eng_valid  (eng_valid),
        .pop        (pop),
        .np_done    (np_done),
        .busy       (busy)
    );

    always_comb begin
        st_d      = st_q;
        req_ready = !fifo_full && !st_q.np_pending;
        accept    = req_valid && req_ready;
        rsp_valid = (accept && (kind == WK_POSTED)) || np_done;
        if (accept && (kind == WK_NONPOSTED)) begin
            st_d.np_pending = 1'b1;
        end else if (np_done) begin
            st_d.np_pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_data  = head_word[DW-1:0];
    assign eng_addr  = head_word[DW +: AW];
    assign eng_be    = head_word[DW+AW +: BW];
    assign eng_cs    = head_word[DW+AW+BW +: CSW];
    assign buf_empty = fifo_empty && !busy;
endmodule

// File: rtl/wpb_chk.sv
module wpb_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       force_post,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       req_posted,
    input logic                       req_nand,
    input logic                       rsp_valid,
    input logic                       eng_valid,
    input logic                       eng_ready,
    input logic [AW-1:0]              eng_addr,
    input logic [DW-1:0]              eng_data,
    input logic                       buf_empty,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    logic eff_post;
    assign eff_post = req_posted || (force_post && req_nand);

    // R2
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == ($clog2(DEPTH+1))'(DEPTH)) |-> !req_ready);

    // R1
    post_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && eff_post) |-> rsp_valid);

    // R4
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_ready) |=> !eng_valid);

    // R6
    np_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !eff_post) |=> !req_ready);

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !eng_valid);

    // R3
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_addr) && $stable(eng_data)));
endmodule

bind wr_post_buf wpb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_post (force_post),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_posted (req_posted),
    .req_nand   (req_nand),
    .rsp_valid  (rsp_valid),
    .eng_valid  (eng_valid),
    .eng_ready  (eng_ready),
    .eng_addr   (eng_addr),
    .eng_data   (eng_data),
    .buf_empty  (buf_empty),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/wr_post_buf_tb_top.sv
module wr_post_buf_tb_top;
    localparam int AW = 8, DW = 16, BW = 2, CSW = 3, DEPTH = 8;

    logic clk = 0, rst_n = 0;
    logic force_post = 0, req_valid = 0, req_posted = 0, req_nand = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [BW-1:0] req_be = '0;
    logic [CSW-1:0] req_cs = '0;
    logic req_ready, rsp_valid, eng_valid, buf_empty;
    logic eng_ready = 0, eng_done = 0;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_data;
    logic [BW-1:0] eng_be;
    logic [CSW-1:0] eng_cs;

    always #2 clk = ~clk;

    wr_post_buf #(.AW(AW), .DW(DW), .BW(BW), .CSW(CSW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .force_post(force_post),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .req_cs(req_cs),
        .req_posted(req_posted), .req_nand(req_nand), .rsp_valid(rsp_valid),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_be(eng_be), .eng_cs(eng_cs),
        .eng_done(eng_done), .buf_empty(buf_empty)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // engine model and logs
    bit eng_en = 0, acc_seen = 0, m_busy = 0, inject = 0;
    int lat = 0, wait_cnt = 0, viol = 0;
    int log_n = 0, exp_n = 0;
    logic [AW+DW+BW+CSW-1:0] log_w [64];
    logic [AW+DW+BW+CSW-1:0] exp_w [64];

    always @(posedge clk) begin
        if (rst_n && eng_valid && eng_ready) begin
            if (log_n < 64) log_w[log_n] = {eng_addr, eng_data, eng_be, eng_cs};
            log_n++;
            acc_seen = 1;
        end
    end

    always @(negedge clk) begin
        eng_done = 0;
        eng_ready = eng_en;
        if (acc_seen) begin
            acc_seen = 0;
            m_busy = 1;
            wait_cnt = lat;
        end
        if (m_busy && eng_valid) viol++;
        if (m_busy) begin
            if (wait_cnt == 0) begin
                eng_done = 1;
                m_busy = 0;
            end else begin
                wait_cnt--;
            end
        end
        if (inject) begin
            eng_done = 1;
            inject = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BW-1:0] b, input logic [CSW-1:0] c,
                            input logic p, input logic n, output logic rsp_now);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d; req_be = b; req_cs = c;
        req_posted = p; req_nand = n;
        #1;
        while (!req_ready) sample();
        rsp_now = rsp_valid;
        if (exp_n < 64) exp_w[exp_n] = {a, d, b, c};
        exp_n++;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_empty(output int cyc);
        cyc = 0;
        while (!buf_empty && cyc < 200) begin
            sample();
            cyc++;
        end
    endtask

    task automatic wait_rsp(output int cyc);
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin
            sample();
            cyc++;
        end
    endtask

    task automatic cmp_log(input string req);
        chk(log_n == exp_n, req, "issued count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < 64; i++)
            chk(log_w[i] == exp_w[i], req, "issue order/payload", int'(log_w[i]), int'(exp_w[i]));
    endtask

    task automatic clr_log();
        log_n = 0; exp_n = 0; viol = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic r;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk(buf_empty == 1, "R10", "buf_empty", buf_empty, 1);
        chk(req_ready == 1, "R10", "req_ready", req_ready, 1);
        chk(eng_valid == 0, "R10", "eng_valid", eng_valid, 0);
        chk(rsp_valid == 0, "R10", "rsp_valid", rsp_valid, 0);

        // R9: stray completion while idle
        inject = 1;
        sample();
        chk(rsp_valid == 0, "R9", "rsp on stray done", rsp_valid, 0);
        sample();
        chk(buf_empty == 1, "R9", "buf_empty after stray done", buf_empty, 1);

        // R1 R2 R3 R4 R8: posted fill sweep against completion latencies
        for (int l = 0; l < 3; l++) begin
            for (int n = 1; n <= DEPTH; n++) begin
                clr_log();
                lat = l;
                eng_en = 0;
                for (int i = 0; i < n; i++) begin
                    do_write(AW'(l * 16 + i), DW'(16'h1000 * l + 16'h0101 * i + n),
                             BW'(i), CSW'(i + n), 1'b1, 1'b0, r);
                    chk(r == 1, "R1", "posted rsp in accept cycle", r, 1);
                end
                #1;
                chk(buf_empty == 0, "R8", "buf_empty with entries", buf_empty, 0);
                chk(req_ready == (n < DEPTH), "R2", "req_ready at fill", req_ready, n < DEPTH);
                eng_en = 1;
                wait_empty(cyc);
                chk(cyc < 200, "R8", "drain reaches empty", cyc, 0);
                chk(viol == 0, "R4", "offer while in flight", viol, 0);
                cmp_log("R3");
                eng_en = 0;
            end
        end

        // R5 R6 R8: nonposted behind posted
        clr_log();
        lat = 1;
        eng_en = 0;
        do_write(8'h40, 16'hA001, 2'b11, 3'd1, 1'b1, 1'b0, r);
        do_write(8'h41, 16'hA002, 2'b01, 3'd2, 1'b1, 1'b0, r);
        do_write(8'h42, 16'hA003, 2'b10, 3'd3, 1'b0, 1'b0, r);
        chk(r == 0, "R5", "nonposted rsp at accept", r, 0);
        #1;
        chk(req_ready == 0, "R6", "req_ready after nonposted", req_ready, 0);
        eng_en = 1;
        wait_rsp(cyc);
        chk(eng_done == 1, "R5", "nonposted rsp aligned with done", eng_done, 1);
        chk(log_n == 3, "R5", "rsp only after own access", log_n, 3);
        chk(req_ready == 0, "R6", "req_ready in done cycle", req_ready, 0);
        chk(buf_empty == 0, "R8", "buf_empty in final done cycle", buf_empty, 0);
        sample();
        chk(req_ready == 1, "R6", "req_ready after done", req_ready, 1);
        chk(buf_empty == 1, "R8", "buf_empty after final done", buf_empty, 1);
        chk(viol == 0, "R4", "offer while in flight", viol, 0);
        cmp_log("R3");

        // R7: all combinations of posted, nand, promotion
        for (int k = 0; k < 8; k++) begin
            logic p, nd, f, ex;
            p = k[0]; nd = k[1]; f = k[2];
            ex = p | (f & nd);
            clr_log();
            lat = 2;
            eng_en = 1;
            force_post = f;
            do_write(AW'(8'h80 + k), DW'(16'h5500 + k), 2'b11, CSW'(k), p, nd, r);
            chk(r == ex, "R7", "response class at accept", r, ex);
            if (!ex) begin
                wait_rsp(cyc);
                chk(eng_done == 1 && cyc < 200, "R5", "late rsp with done", eng_done, 1);
            end
            wait_empty(cyc);
            chk(buf_empty == 1, "R8", "idle after write", buf_empty, 1);
            cmp_log("R3");
        end
        force_post = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule